// File: doc/BRIEF.md
# Linked-Tag Quadword DMA Reader

This block is a single-channel DMA read engine. It fetches 128-bit quadwords from memory and delivers them in order on a valid/ready output stream. Software programs it through a four-entry register port that holds a control word, a memory pointer, a tag pointer and a quadword count. The engine then works without further help and clears its go bit once everything it read has left the output.

The engine has two modes. In linear mode it copies a contiguous run of quadwords from the memory pointer. In linked mode it starts by reading a descriptor quadword at the tag pointer. Only the lower 64 bits of a descriptor matter. The type field of each descriptor selects two things: whether the link's payload sits inline right after the descriptor or at an address the descriptor carries, and where the next descriptor comes from. Payload from links scattered across memory therefore leaves the block as one ordered stream.

Memory is read through a request/ready port with a separate response strobe, and at most one read is in flight. A small output FIFO absorbs backpressure, and reads are issued only when the FIFO has a free slot.

Top module: `qw_chain_dma`

## Requirements
- R1: Addresses are quadword granular. Bits [3:0] of every memory request address are 0, and the memory and tag pointer registers read back with bits [3:0] forced to 0, whatever was written.
- R2: In linear mode (control bit1 = 0), writing control bit0 = 1 emits exactly `count` quadwords, read from ascending addresses starting at the memory pointer.
- R3: Control bit0 reads 1 from the cycle after the start write until the last quadword of the transfer has been accepted on the output, and 0 afterwards. After a linear transfer, the count reads 0 and the memory pointer reads start + 16 × count. After reset, all registers read 0 and no request or output is active.
- R4: In linked mode (control bit1 = 1), the first descriptor is read from the tag pointer. Descriptor bits [15:0] hold the count, bits [30:28] hold the type and bits [62:32] hold a byte address. Bits [127:64] of a descriptor have no effect.
- R5: Type 1 (inline-continue): the `count` quadwords after the descriptor are emitted, and the next descriptor is the quadword after that payload.
- R6: Type 2 (inline-jump): the `count` quadwords after the descriptor are emitted, and the next descriptor is read from the descriptor's address field.
- R7: Type 3 (remote-continue): `count` quadwords are emitted starting at the address field, and the next descriptor is the quadword after the current descriptor.
- R8: Type 0 (remote-last) emits `count` quadwords from the address field and ends the chain. Type 7 (inline-last) emits the `count` quadwords after the descriptor and ends the chain.
- R9: A descriptor with count 0 emits nothing but still applies its next-descriptor or end rule.
- R10: A descriptor of any other type stops the chain without emitting its payload and sets error bit 2 of the control register. The error bit clears when the next transfer starts.
- R11: While the output is valid and not ready, the output data is held. Every quadword is delivered exactly once, in order.
- R12: No new memory request is raised while a read is outstanding. A request that is not taken holds its address until it is taken.
- R13: Register writes made while control bit0 reads 1 are ignored.
- R14: A four-link chain of inline-jump, remote-continue, inline-continue and inline-last descriptors, with tags and data scattered in memory, emits its payload in link order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 memory pointer, 2 tag pointer, 3 count |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the requested quadword |
| mem_ready | input | 1 | Memory takes the request in this cycle |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | DW | Read response quadword |
| out_valid | output | 1 | Output quadword valid |
| out_data | output | DW | Output quadword |
| out_ready | input | 1 | Sink takes the output quadword |

## Verification
A wrong next-descriptor pointer does not cause a protocol fault. It shows up at the ports as the wrong quadwords in the stream, either a descriptor's raw bits sent as data or a jump to the wrong place. It is seen on the first quadword of the following link. A miscounted link shifts every later quadword and leaves a nonzero count or a wrong final pointer for software to read once the go bit drops. Lost or repeated quadwords under backpressure, and overlapping reads, appear within a cycle as a changed held output or a second request before the response.

// File: rtl/qwdma_pkg.sv
package qwdma_pkg;

   // descriptor type codes (bits [30:28] of a descriptor)
   localparam logic [2:0] KIND_REMOTE_LAST = 3'd0;
   localparam logic [2:0] KIND_INLINE_CONT = 3'd1;
   localparam logic [2:0] KIND_INLINE_JUMP = 3'd2;
   localparam logic [2:0] KIND_REMOTE_CONT = 3'd3;
   localparam logic [2:0] KIND_INLINE_LAST = 3'd7;

   localparam int TAG_CNT_W  = 16;
   localparam int TAG_ADDR_W = 31;

   // register selects
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_MPTR = 2'd1;
   localparam logic [1:0] SEL_TPTR = 2'd2;
   localparam logic [1:0] SEL_QCNT = 2'd3;

   // control bit positions
   localparam int CB_GO    = 0;
   localparam int CB_CHAIN = 1;
   localparam int CB_ERR   = 2;

   typedef struct packed {
      logic [TAG_CNT_W-1:0]  qwc;
      logic [2:0]            kind;
      logic [TAG_ADDR_W-1:0] addr;
   } tag_fields_t;

   typedef struct packed {
      logic inline_data;      // payload follows the descriptor
      logic next_after_data;  // next descriptor follows the payload
      logic next_from_field;  // next descriptor at the address field
      logic next_after_tag;   // next descriptor follows this descriptor
      logic last;             // chain ends after this link
      logic bad;              // unknown type
   } tag_plan_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_TAG_REQ,
      S_TAG_WAIT,
      S_DAT_REQ,
      S_DAT_WAIT,
      S_LINK_END,
      S_DRAIN
   } seq_state_e;

endpackage

// File: rtl/qwdma_tag_decode.sv
module qwdma_tag_decode
   import qwdma_pkg::*;
(
   input  logic [63:0] tag_lo,
   output tag_fields_t fields,
   output tag_plan_t   plan
);

   logic unused_tag_bits;
   assign unused_tag_bits = ^{tag_lo[63], tag_lo[31], tag_lo[27:16]};

   always_comb begin
      fields.qwc  = tag_lo[15:0];
      fields.kind = tag_lo[30:28];
      fields.addr = tag_lo[62:32];
      plan = '0;
      unique case (fields.kind)
         KIND_REMOTE_LAST: plan.last = 1'b1;
         KIND_INLINE_CONT: begin
            plan.inline_data     = 1'b1;
            plan.next_after_data = 1'b1;
         end
         KIND_INLINE_JUMP: begin
            plan.inline_data     = 1'b1;
            plan.next_from_field = 1'b1;
         end
         KIND_REMOTE_CONT: plan.next_after_tag = 1'b1;
         KIND_INLINE_LAST: begin
            plan.inline_data = 1'b1;
            plan.last        = 1'b1;
         end
         default: plan.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/qwdma_out_fifo.sv
module qwdma_out_fifo #(
   parameter int W     = 128,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready,
   output logic         space,
   output logic         empty
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("qwdma_out_fifo: DEPTH must be at least 1");
   end

   logic pop;
   assign pop = out_valid & out_ready;

   if (DEPTH == 1) begin : g_single
      logic         full_q;
      logic [W-1:0] data_q;

      always_ff @(posedge clk) begin
         if (!rst_n) full_q <= 1'b0;
         else        full_q <= push | (full_q & ~pop);
      end

      always_ff @(posedge clk) begin
         if (push) data_q <= din;
      end

      assign out_valid = full_q;
      assign out_data  = data_q;
      assign space     = ~full_q;
      assign empty     = ~full_q;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);

      logic [W-1:0]  slot [DEPTH];
      logic [PW-1:0] wp, rp;
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
         end
      end

      always_ff @(posedge clk) begin
         if (push) slot[wp] <= din;
      end

      assign out_valid = (cnt != '0);
      assign out_data  = slot[rp];
      assign space     = (cnt < CW'(DEPTH));
      assign empty     = (cnt == '0);
   end

endmodule

// File: rtl/qwdma_seq.sv
module qwdma_seq
   import qwdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [1:0]           cfg_sel,
   input  logic [31:0]          cfg_wdata,
   output logic                 busy,
   output logic                 chain_mode,
   output logic                 err_flag,
   output logic [AW-1:0]        mem_ptr,
   output logic [AW-1:0]        tag_ptr,
   output logic [TAG_CNT_W-1:0] qw_left,
   input  tag_fields_t          tag_f,
   input  tag_plan_t            tag_p,
   output logic                 mem_req,
   output logic [AW-1:0]        mem_addr,
   input  logic                 mem_ready,
   input  logic                 mem_rvalid,
   output logic                 push,
   input  logic                 fifo_space,
   input  logic                 fifo_empty
);

   localparam int            LSB  = $clog2(DW / 8);
   localparam logic [AW-1:0] STEP = AW'(DW / 8);
   localparam logic [AW-1:0] LOWM = AW'((1 << LSB) - 1);

   function automatic logic [AW-1:0] align_f(input logic [AW-1:0] a);
      return a & ~LOWM;
   endfunction

   seq_state_e st;
   logic       last_link;
   logic       next_after_data;
   logic       wr_ok;

   assign busy  = (st != S_IDLE);
   assign wr_ok = cfg_wr & ~busy;

   always_comb begin
      mem_req  = (st == S_TAG_REQ) |
                 ((st == S_DAT_REQ) & (qw_left != '0) & fifo_space);
      mem_addr = (st == S_TAG_REQ) ? tag_ptr : mem_ptr;
      push     = (st == S_DAT_WAIT) & mem_rvalid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st              <= S_IDLE;
         chain_mode      <= 1'b0;
         err_flag        <= 1'b0;
         mem_ptr         <= '0;
         tag_ptr         <= '0;
         qw_left         <= '0;
         last_link       <= 1'b0;
         next_after_data <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (wr_ok) begin
                  unique case (cfg_sel)
                     SEL_CTRL: begin
                        chain_mode <= cfg_wdata[CB_CHAIN];
                        if (cfg_wdata[CB_GO]) begin
                           err_flag <= 1'b0;
                           st <= cfg_wdata[CB_CHAIN] ? S_TAG_REQ : S_DAT_REQ;
                        end
                     end
                     SEL_MPTR: mem_ptr <= align_f(AW'(cfg_wdata));
                     SEL_TPTR: tag_ptr <= align_f(AW'(cfg_wdata));
                     SEL_QCNT: qw_left <= cfg_wdata[TAG_CNT_W-1:0];
                     default: ;
                  endcase
               end
            end
            S_TAG_REQ: begin
               if (mem_ready) st <= S_TAG_WAIT;
            end
            S_TAG_WAIT: begin
               if (mem_rvalid) begin
                  if (tag_p.bad) begin
                     err_flag <= 1'b1;
                     st       <= S_DRAIN;
                  end else begin
                     qw_left         <= tag_f.qwc;
                     mem_ptr         <= tag_p.inline_data ? tag_ptr + STEP
                                                          : align_f(AW'(tag_f.addr));
                     last_link       <= tag_p.last;
                     next_after_data <= tag_p.next_after_data;
                     if (tag_p.next_from_field)
                        tag_ptr <= align_f(AW'(tag_f.addr));
                     else if (tag_p.next_after_tag)
                        tag_ptr <= tag_ptr + STEP;
                     st <= S_DAT_REQ;
                  end
               end
            end
            S_DAT_REQ: begin
               if (qw_left == '0)
                  st <= chain_mode ? S_LINK_END : S_DRAIN;
               else if (fifo_space & mem_ready)
                  st <= S_DAT_WAIT;
            end
            S_DAT_WAIT: begin
               if (mem_rvalid) begin
                  mem_ptr <= mem_ptr + STEP;
                  qw_left <= qw_left - TAG_CNT_W'(1);
                  st      <= S_DAT_REQ;
               end
            end
            S_LINK_END: begin
               if (last_link) begin
                  st <= S_DRAIN;
               end else begin
                  if (next_after_data) tag_ptr <= mem_ptr;
                  st <= S_TAG_REQ;
               end
            end
            S_DRAIN: begin
               if (fifo_empty) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/qw_chain_dma.sv
module qw_chain_dma
   import qwdma_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 128,
   parameter int FIFO_DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_sel,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ready,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          out_ready
);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("qw_chain_dma: AW must lie in 8..32");
   end
   if (DW < 64 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("qw_chain_dma: DW must be a power of two of at least 64");
   end

   tag_fields_t          tag_f;
   tag_plan_t            tag_p;
   logic                 busy, chain_mode, err_flag;
   logic [AW-1:0]        mem_ptr, tag_ptr;
   logic [TAG_CNT_W-1:0] qw_left;
   logic                 push, fifo_space, fifo_empty;

   qwdma_tag_decode u_dec (
      .tag_lo (mem_rdata[63:0]),
      .fields (tag_f),
      .plan   (tag_p)
   );

   qwdma_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .busy       (busy),
      .chain_mode (chain_mode),
      .err_flag   (err_flag),
      .mem_ptr    (mem_ptr),
      .tag_ptr    (tag_ptr),
      .qw_left    (qw_left),
      .tag_f      (tag_f),
      .tag_p      (tag_p),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ready  (mem_ready),
      .mem_rvalid (mem_rvalid),
      .push       (push),
      .fifo_space (fifo_space),
      .fifo_empty (fifo_empty)
   );

   qwdma_out_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .din       (mem_rdata),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready),
      .space     (fifo_space),
      .empty     (fifo_empty)
   );

   always_comb begin
      unique case (cfg_sel)
         SEL_CTRL: begin
            cfg_rdata         = '0;
            cfg_rdata[CB_GO]    = busy;
            cfg_rdata[CB_CHAIN] = chain_mode;
            cfg_rdata[CB_ERR]   = err_flag;
         end
         SEL_MPTR: cfg_rdata = 32'(mem_ptr);
         SEL_TPTR: cfg_rdata = 32'(tag_ptr);
         SEL_QCNT: cfg_rdata = 32'(qw_left);
         default:  cfg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/qwdma_props.sv
module qwdma_props #(
   parameter int AW = 32,
   parameter int DW = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ready,
   input logic          mem_rvalid,
   input logic          out_valid,
   input logic [DW-1:0] out_data,
   input logic          out_ready
);

   localparam int LSB = $clog2(DW / 8);

   logic in_flight;

   always_ff @(posedge clk) begin
      if (!rst_n)                    in_flight <= 1'b0;
      else if (mem_req && mem_ready) in_flight <= 1'b1;
      else if (mem_rvalid)           in_flight <= 1'b0;
   end

   // R1: quadword-aligned request addresses
   p_aligned_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[LSB-1:0] == '0));

   // R12: single outstanding read
   p_single_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight |-> !mem_req);

   // R12: a response only answers a taken request
   p_resp_matched_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> in_flight);

   // R12: a waiting request keeps its address
   p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   // R11: stalled output holds its data
   p_out_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind qw_chain_dma qwdma_props #(.AW(AW), .DW(DW)) u_props (.*);

// File: tb/sim_qw_chain_dma.sv
module sim_qw_chain_dma;

   localparam int AW = 32;
   localparam int DW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [1:0]    cfg_sel = 2'd0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ready = 1'b0;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          out_ready = 1'b0;

   always #4 clk = ~clk;

   qw_chain_dma #(.AW(AW), .DW(DW), .FIFO_DEPTH(2)) u0 (.*);

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [127:0] mem [512];
   logic [127:0] got_q [$];
   logic [127:0] exp_q [$];

   int         stall_mode = 0;  // memory: 0 fast, 1 random stalls
   int         rdy_mode   = 0;  // sink: 0 always, 1 random, 2 held low
   logic [15:0] lfsr = 16'hACE1;
   bit         pend = 1'b0;
   int         pidx = 0;
   int         lat  = 0;

   function automatic logic [127:0] pat(input int a);
      int i;
      i = a >> 4;
      return {32'hD0D0_0000 | 32'(i), ~32'(i), 32'(i) ^ 32'h5A5A_5A5A, 32'(i) + 32'h1000};
   endfunction

   function automatic logic [127:0] mk_tag(input logic [2:0] kind, input int addr,
                                           input int qwc, input logic [63:0] hi);
      return {hi, 1'b0, 31'(addr), 1'b0, kind, 12'h000, 16'(qwc)};
   endfunction

   // memory and sink model, driven away from the active edge
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_rvalid = 1'b0;
      if (pend) begin
         if (lat == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[pidx];
            pend       = 1'b0;
         end else begin
            lat = lat - 1;
         end
      end
      mem_ready = (stall_mode == 0) ? 1'b1 : lfsr[0];
      if (rst_n && mem_req && mem_ready) begin
         pend = 1'b1;
         pidx = int'(mem_addr[12:4]);
         lat  = (stall_mode == 0) ? 0 : int'(lfsr[3:2]);
      end
      out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[5] : 1'b0;
      if (rst_n && out_valid && out_ready) got_q.push_back(out_data);
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
      @(negedge clk);
      cfg_sel   = sel;
      cfg_wdata = val;
      cfg_wr    = 1'b1;
      @(negedge clk);
      cfg_wr    = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
      @(negedge clk);
      cfg_sel = sel;
      #1 val = cfg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int k = 0; k < 20000; k++) begin
         reg_read(2'd0, v);
         if (!v[0]) break;
      end
   endtask

   task automatic expect_run(input int addr, input int n);
      for (int k = 0; k < n; k++) exp_q.push_back(pat(addr + 16 * k));
   endtask

   task automatic cmp_stream(input string req);
      chk(got_q.size() == exp_q.size(), req, 128'(got_q.size()), 128'(exp_q.size()));
      if (got_q.size() == exp_q.size())
         for (int k = 0; k < exp_q.size(); k++)
            chk(got_q[k] == exp_q[k], req, got_q[k], exp_q[k]);
      got_q.delete();
      exp_q.delete();
   endtask

   // R3: reset state
   task automatic t_reset();
      logic [31:0] v;
      for (int s = 0; s < 4; s++) begin
         reg_read(2'(s), v);
         chk(v == 32'h0, "R3 reset register", 128'(v), 128'h0);
      end
      chk(!mem_req && !out_valid, "R3 reset outputs idle", 128'({mem_req, out_valid}), 128'h0);
   endtask

   // R1 R2 R3: linear copy and final register values
   task automatic t_linear();
      logic [31:0] v;
      reg_write(2'd1, 32'h0000_020F);
      reg_read(2'd1, v);
      chk(v == 32'h200, "R1 pointer low bits cleared", 128'(v), 128'h200);
      reg_write(2'd2, 32'h0000_0307);
      reg_read(2'd2, v);
      chk(v == 32'h300, "R1 tag pointer low bits cleared", 128'(v), 128'h300);
      reg_write(2'd3, 32'd5);
      reg_write(2'd0, 32'h1);
      reg_read(2'd0, v);
      chk(v[0] == 1'b1, "R3 go reads 1 while busy", 128'(v[0]), 128'h1);
      expect_run(32'h200, 5);
      wait_idle();
      cmp_stream("R2 linear stream");
      reg_read(2'd1, v);
      chk(v == 32'h250, "R3 final memory pointer", 128'(v), 128'h250);
      reg_read(2'd3, v);
      chk(v == 32'h0, "R3 final count", 128'(v), 128'h0);
   endtask

   // R11: stalls on both sides
   task automatic t_backpressure();
      stall_mode = 1;
      rdy_mode   = 1;
      reg_write(2'd1, 32'h0000_0400);
      reg_write(2'd3, 32'd9);
      reg_write(2'd0, 32'h1);
      expect_run(32'h400, 9);
      wait_idle();
      cmp_stream("R11 stream under backpressure");
      stall_mode = 0;
      rdy_mode   = 0;
   endtask

   // R4 R5 R6 R7 R8 R14: scattered four-link chain
   task automatic t_example_chain();
      logic [31:0] v;
      mem[16'h0000 >> 4] = mk_tag(3'd2, 32'h0030, 2, 64'hFFFF_3000_0000_0005);
      mem[16'h0030 >> 4] = mk_tag(3'd3, 32'h1000, 2, 64'h7000_0000_7000_0001);
      mem[16'h0040 >> 4] = mk_tag(3'd1, 32'h0000, 2, 64'h1234_5678_9ABC_DEF0);
      mem[16'h0070 >> 4] = mk_tag(3'd7, 32'h0000, 2, 64'h0);
      stall_mode = 1;
      rdy_mode   = 1;
      reg_write(2'd2, 32'h0);
      reg_write(2'd0, 32'h3);
      expect_run(32'h0010, 2);
      expect_run(32'h1000, 2);
      expect_run(32'h0050, 2);
      expect_run(32'h0080, 2);
      wait_idle();
      cmp_stream("R14 R5 R6 R7 R8 R4 chain order");
      reg_read(2'd3, v);
      chk(v == 32'h0, "R8 chain final count", 128'(v), 128'h0);
      reg_read(2'd1, v);
      chk(v == 32'h00A0, "R8 chain final memory pointer", 128'(v), 128'hA0);
      reg_read(2'd0, v);
      chk(v[2] == 1'b0, "R4 no error on valid chain", 128'(v), 128'h2);
      stall_mode = 0;
      rdy_mode   = 0;
   endtask

   // R9 R8: zero-count links and remote-last
   task automatic t_zero_links();
      mem[16'h0300 >> 4] = mk_tag(3'd1, 32'h0000, 0, 64'h0);
      mem[16'h0310 >> 4] = mk_tag(3'd2, 32'h0340, 0, 64'h0);
      mem[16'h0340 >> 4] = mk_tag(3'd3, 32'h03A0, 1, 64'h0);
      mem[16'h0350 >> 4] = mk_tag(3'd0, 32'h03C0, 2, 64'h0);
      reg_write(2'd2, 32'h300);
      reg_write(2'd0, 32'h3);
      expect_run(32'h3A0, 1);
      expect_run(32'h3C0, 2);
      wait_idle();
      cmp_stream("R9 R7 R8 zero-count links");
      mem[16'h0380 >> 4] = mk_tag(3'd7, 32'h0000, 0, 64'h0);
      reg_write(2'd2, 32'h380);
      reg_write(2'd0, 32'h3);
      wait_idle();
      cmp_stream("R9 empty last link emits nothing");
   endtask

   // R10: unknown type
   task automatic t_bad_kind();
      logic [31:0] v;
      mem[16'h0390 >> 4] = mk_tag(3'd5, 32'h0200, 3, 64'h0);
      reg_write(2'd2, 32'h390);
      reg_write(2'd0, 32'h3);
      wait_idle();
      cmp_stream("R10 nothing emitted on bad type");
      reg_read(2'd0, v);
      chk(v == 32'h6, "R10 error flag set, go clear", 128'(v), 128'h6);
      reg_write(2'd1, 32'h200);
      reg_write(2'd3, 32'd1);
      reg_write(2'd0, 32'h1);
      expect_run(32'h200, 1);
      wait_idle();
      cmp_stream("R10 following linear run");
      reg_read(2'd0, v);
      chk(v == 32'h0, "R10 error cleared by start", 128'(v), 128'h0);
   endtask

   // R13: writes while busy are ignored
   task automatic t_busy_writes();
      logic [31:0] v;
      rdy_mode = 2;
      reg_write(2'd1, 32'h200);
      reg_write(2'd3, 32'd4);
      reg_write(2'd0, 32'h1);
      reg_write(2'd1, 32'h440);
      reg_write(2'd3, 32'd9);
      reg_write(2'd0, 32'h3);
      rdy_mode = 0;
      expect_run(32'h200, 4);
      wait_idle();
      cmp_stream("R13 stream unaffected by busy writes");
      reg_read(2'd1, v);
      chk(v == 32'h240, "R13 pointer write ignored", 128'(v), 128'h240);
      reg_read(2'd0, v);
      chk(v == 32'h0, "R13 control write ignored", 128'(v), 128'h0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = pat(i * 16);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_linear();
      t_backpressure();
      t_example_chain();
      t_zero_links();
      t_bad_kind();
      t_busy_writes();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule